// File: doc/BRIEF.md
# Delta-Sigma Converter SPI Host Sequencer

This block is the host side of a serial link to an external delta-sigma converter. After its own reset it waits for the converter's supplies and internal reset to settle. It can then send a reset opcode and wait for the converter's clock domain to recover. It can poll the converter's status register until the busy bit clears, and then clear the power-on flag. Next it writes a bank of configuration registers, reads the bank back, and compares each byte. Finally it starts continuous conversion. From then on, every falling edge of the active-low data-ready input triggers one result read, and the 16-bit word is presented with a one-cycle strobe. A stop request lets the read in flight finish, then sends the stop opcode and parks the block.

The sequencer is a single state machine. Its states are ST_PWRUP (settle wait), ST_RESET (reset opcode frame), ST_RSTWAIT (recovery wait), ST_STATRD (status read), ST_STATCLR (status clear), ST_CFGWR (bank write), ST_CFGRD (bank readback), ST_START (start opcode), ST_IDLE (wait for data-ready or stop), ST_RDATA (result read), ST_STOP (stop opcode) and ST_HALT.

The transitions are as follows. ST_PWRUP goes to ST_RESET when its timer expires. ST_RESET goes to ST_RSTWAIT at the end of its frame, and ST_RSTWAIT goes to ST_STATRD when its timer expires. ST_STATRD returns to itself while the busy bit is set and otherwise goes to ST_STATCLR. The chain then runs ST_STATCLR, ST_CFGWR, ST_CFGRD, ST_START and ST_IDLE, each step taken at a frame end. ST_IDLE goes to ST_STOP when a stop is pending, and otherwise to ST_RDATA when a data-ready edge is pending. ST_RDATA returns to ST_IDLE. ST_STOP goes to ST_HALT.

Each frame runs through four phases: chip select off, setup, shift and hold. A byte-wide SPI mode 1 shifter sits under the frame phases. The two optional steps can be dropped by parameter.

Top module: `adc_seq_host`

## Requirements
- R1: While reset is held, cs_n is 1, sclk is 0, result_valid is 0 and cfg_err is 0. After reset is released, cs_n does not fall before PWRUP_CYC clock cycles have passed.
- R2: sclk is 0 whenever cs_n is 1. mosi changes only in the cycle in which sclk rises. miso is sampled when sclk falls. Bits go most significant first.
- R3: In each frame, the first rising edge of sclk comes at least CS_SETUP_CYC cycles after cs_n falls. cs_n rises at least CS_HOLD_CYC cycles after the last falling edge of sclk. Every frame is its own cs_n low period.
- R4: With the reset step enabled, the first frame is the single byte 06h. The next frame begins no earlier than RSTWAIT_CYC cycles after that frame's cs_n rise.
- R5: With the status step enabled, the sequencer sends the frame 21h, 00h, 00h and takes the third received byte as status. While bit 6 of that byte is 1, the read is repeated. After it reads 0, the frame 41h, 00h, 00h is sent.
- R6: The bank write frame is (40h+CFG_BASE), (NREG-1), then bytes k = 0 to NREG-1, where byte k is cfg_regs[8k+7:8k]. The readback frame is (20h+CFG_BASE), (NREG-1), then NREG bytes of 00h. cfg_err becomes 1 if any received byte differs from the byte written at the same position. Once set, it stays 1 until reset.
- R7: After readback, the single-byte frame 08h is sent.
- R8: A falling edge on drdy_n in ST_IDLE causes the frame 12h, 00h, 00h. result takes byte 2 as its upper half and byte 3 as its lower half. result_valid is 1 for exactly the one cycle in which that frame's cs_n returns high.
- R9: A falling edge on drdy_n that arrives while a read frame is active is kept. It causes one further read frame after the current one.
- R10: Once stop_req has been seen as 1, a read frame in progress completes with its result. Then the single-byte frame 0Ah is sent. After that, cs_n stays 1 and further drdy_n edges have no effect.
- R11: Holding drdy_n low for many cycles produces exactly one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_regs | input | NREG*8 | Configuration bytes; byte k goes to register CFG_BASE+k |
| drdy_n | input | 1 | Active-low data-ready from the converter (asynchronous) |
| stop_req | input | 1 | Request to stop conversions |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the converter |
| result | output | 16 | Last conversion word |
| result_valid | output | 1 | One-cycle strobe for a new result |
| cfg_err | output | 1 | Sticky readback mismatch flag |

## Verification
The assertions check four things on every cycle:
- the serial clock stays idle while chip select is high, and mosi moves only on a rising edge;
- the chip-select setup and hold spacing;
- the result strobe lasts one cycle and coincides with chip select rising;
- the mismatch flag is sticky, and the halted state keeps chip select high.

Other behaviour is shown only by the bench scenarios, which run against a converter model:
- the order and content of the frames;
- repeated status polls while the busy bit is set;
- detection of a corrupted readback;
- a data-ready edge kept across a busy frame;
- a long-held data-ready giving a single read;
- the drain-then-stop sequence and silence afterwards.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_RESET,
        ST_RSTWAIT,
        ST_STATRD,
        ST_STATCLR,
        ST_CFGWR,
        ST_CFGRD,
        ST_START,
        ST_IDLE,
        ST_RDATA,
        ST_STOP,
        ST_HALT
    } seq_state_t;

    typedef enum logic [1:0] {
        FP_OFF,
        FP_SETUP,
        FP_SHIFT,
        FP_HOLD
    } frame_phase_t;

    localparam logic [7:0] OP_RESET    = 8'h06;
    localparam logic [7:0] OP_START    = 8'h08;
    localparam logic [7:0] OP_STOP     = 8'h0A;
    localparam logic [7:0] OP_RDATA    = 8'h12;
    localparam logic [7:0] OP_RREG     = 8'h20;
    localparam logic [7:0] OP_WREG     = 8'h40;
    localparam logic [7:0] STATUS_ADDR = 8'h01;
    localparam int         STAT_BUSY_BIT = 6;

endpackage

// File: rtl/adc_drdy_edge.sv
module adc_drdy_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic drdy_n,
    output logic fall
);
    // two synchroniser flops plus one history flop
    logic [2:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 3'b111;
        else        sync_q <= {sync_q[1:0], drdy_n};
    end

    assign fall = sync_q[2] & ~sync_q[1];

endmodule

// File: rtl/adc_spi_byte.sv
module adc_spi_byte #(
    parameter int HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       done
);
    localparam int HW = $clog2(HALF + 1);

    logic          busy;
    logic [2:0]    bitn;
    logic [HW-1:0] hcnt;
    logic [6:0]    sh;
    logic          half_end;

    assign half_end = (hcnt == HW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            bitn <= '0;
            hcnt <= '0;
            sh   <= '0;
            sclk <= 1'b0;
            mosi <= 1'b0;
            rx   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy <= 1'b1;
                    sclk <= 1'b1;
                    mosi <= tx[7];
                    sh   <= tx[6:0];
                    bitn <= '0;
                    hcnt <= '0;
                end
            end else if (!half_end) begin
                hcnt <= hcnt + 1'b1;
            end else begin
                hcnt <= '0;
                if (sclk) begin
                    sclk <= 1'b0;
                    rx   <= {rx[6:0], miso};
                end else if (bitn == 3'd7) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    bitn <= bitn + 1'b1;
                    sclk <= 1'b1;
                    mosi <= sh[6];
                    sh   <= {sh[5:0], 1'b0};
                end
            end
        end
    end

    // R2: data line only moves together with a rising clock
    p_mosi_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sclk) |-> $stable(mosi));

    // R2: a new byte is only launched into an idle shifter
    p_go_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);

endmodule

// File: rtl/adc_seq_host.sv
module adc_seq_host
    import adc_seq_pkg::*;
#(
    parameter int SCLK_HALF    = 4,
    parameter int PWRUP_CYC    = 550000,
    parameter int RSTWAIT_CYC  = 250000,
    parameter int CS_SETUP_CYC = 8,
    parameter int CS_HOLD_CYC  = 8,
    parameter int NREG         = 4,
    parameter int CFG_BASE     = 2,
    parameter bit DO_RESET     = 1'b1,
    parameter bit DO_STATUS    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG*8-1:0] cfg_regs,
    input  logic              drdy_n,
    input  logic              stop_req,
    input  logic              miso,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    output logic [15:0]       result,
    output logic              result_valid,
    output logic              cfg_err
);
    localparam int T_A  = (PWRUP_CYC > RSTWAIT_CYC) ? PWRUP_CYC : RSTWAIT_CYC;
    localparam int T_B  = (CS_SETUP_CYC > CS_HOLD_CYC) ? CS_SETUP_CYC : CS_HOLD_CYC;
    localparam int TMAX = (T_A > T_B) ? T_A : T_B;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int IW   = $clog2(NREG + 3);
    localparam logic [7:0] BASE8 = 8'(CFG_BASE);
    localparam logic [7:0] CNT8  = 8'(NREG - 1);
    localparam seq_state_t AFTER_RST = DO_STATUS ? ST_STATRD : ST_CFGWR;
    localparam seq_state_t AFTER_PWR = DO_RESET ? ST_RESET : AFTER_RST;

    seq_state_t   state, st_nx;
    frame_phase_t phase;
    logic [TW-1:0] timer;
    logic [IW-1:0] idx, flen;
    logic [7:0]   tx_byte, cfg_sel, rx_byte, res_hi, res_lo;
    logic         go, byte_done, drdy_fall;
    logic         drdy_pend, stop_pend, stat_busy, pend_clr;
    logic         frame_end, timer_zero, in_frame;

    adc_drdy_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .drdy_n (drdy_n),
        .fall   (drdy_fall)
    );

    adc_spi_byte #(.HALF(SCLK_HALF)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .tx    (tx_byte),
        .miso  (miso),
        .sclk  (sclk),
        .mosi  (mosi),
        .rx    (rx_byte),
        .done  (byte_done)
    );

    assign timer_zero = (timer == '0);
    assign frame_end  = (phase == FP_HOLD) && timer_zero;
    assign in_frame   = (state != ST_PWRUP) && (state != ST_RSTWAIT) &&
                        (state != ST_IDLE)  && (state != ST_HALT);
    assign pend_clr   = ((state == ST_IDLE) && !stop_pend && drdy_pend) ||
                        ((state == ST_START) && frame_end);

    // frame content: byte to send and frame length for the current state
    always_comb begin
        cfg_sel = 8'h00;
        for (int k = 0; k < NREG; k++) begin
            if (idx == IW'(k + 2)) cfg_sel = cfg_regs[k*8 +: 8];
        end
        tx_byte = 8'h00;
        flen    = IW'(1);
        unique case (state)
            ST_RESET:   tx_byte = OP_RESET;
            ST_STATRD: begin
                flen = IW'(3);
                if (idx == '0) tx_byte = OP_RREG + STATUS_ADDR;
            end
            ST_STATCLR: begin
                flen = IW'(3);
                if (idx == '0) tx_byte = OP_WREG + STATUS_ADDR;
            end
            ST_CFGWR: begin
                flen = IW'(NREG + 2);
                if (idx == '0)          tx_byte = OP_WREG + BASE8;
                else if (idx == IW'(1)) tx_byte = CNT8;
                else                    tx_byte = cfg_sel;
            end
            ST_CFGRD: begin
                flen = IW'(NREG + 2);
                if (idx == '0)          tx_byte = OP_RREG + BASE8;
                else if (idx == IW'(1)) tx_byte = CNT8;
            end
            ST_START:   tx_byte = OP_START;
            ST_RDATA: begin
                flen = IW'(3);
                if (idx == '0) tx_byte = OP_RDATA;
            end
            ST_STOP:    tx_byte = OP_STOP;
            default:    ;
        endcase
    end

    // next-state logic
    always_comb begin
        st_nx = state;
        unique case (state)
            ST_PWRUP:   if (timer_zero) st_nx = AFTER_PWR;
            ST_RESET:   if (frame_end)  st_nx = ST_RSTWAIT;
            ST_RSTWAIT: if (timer_zero) st_nx = AFTER_RST;
            ST_STATRD:  if (frame_end)  st_nx = stat_busy ? ST_STATRD : ST_STATCLR;
            ST_STATCLR: if (frame_end)  st_nx = ST_CFGWR;
            ST_CFGWR:   if (frame_end)  st_nx = ST_CFGRD;
            ST_CFGRD:   if (frame_end)  st_nx = ST_START;
            ST_START:   if (frame_end)  st_nx = ST_IDLE;
            ST_IDLE: begin
                if (stop_pend)      st_nx = ST_STOP;
                else if (drdy_pend) st_nx = ST_RDATA;
            end
            ST_RDATA:   if (frame_end)  st_nx = ST_IDLE;
            ST_STOP:    if (frame_end)  st_nx = ST_HALT;
            ST_HALT:    st_nx = ST_HALT;
            default:    st_nx = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PWRUP;
        else        state <= st_nx;
    end

    // frame sequencing, timers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase        <= FP_OFF;
            timer        <= TW'(PWRUP_CYC);
            idx          <= '0;
            cs_n         <= 1'b1;
            go           <= 1'b0;
            drdy_pend    <= 1'b0;
            stop_pend    <= 1'b0;
            stat_busy    <= 1'b1;
            res_hi       <= '0;
            res_lo       <= '0;
            result       <= '0;
            result_valid <= 1'b0;
            cfg_err      <= 1'b0;
        end else begin
            go           <= 1'b0;
            result_valid <= 1'b0;
            if (drdy_fall)     drdy_pend <= 1'b1;
            else if (pend_clr) drdy_pend <= 1'b0;
            if (stop_req) stop_pend <= 1'b1;

            unique case (phase)
                FP_OFF: begin
                    if (in_frame) begin
                        cs_n  <= 1'b0;
                        phase <= FP_SETUP;
                        timer <= TW'(CS_SETUP_CYC);
                        idx   <= '0;
                    end else if (!timer_zero) begin
                        timer <= timer - 1'b1;
                    end
                end
                FP_SETUP: begin
                    if (!timer_zero) begin
                        timer <= timer - 1'b1;
                    end else begin
                        go    <= 1'b1;
                        phase <= FP_SHIFT;
                    end
                end
                FP_SHIFT: begin
                    if (byte_done) begin
                        if (state == ST_STATRD && idx == IW'(2))
                            stat_busy <= rx_byte[STAT_BUSY_BIT];
                        if (state == ST_CFGRD && idx >= IW'(2) && rx_byte != cfg_sel)
                            cfg_err <= 1'b1;
                        if (state == ST_RDATA && idx == IW'(1)) res_hi <= rx_byte;
                        if (state == ST_RDATA && idx == IW'(2)) res_lo <= rx_byte;
                        if (idx == flen - 1'b1) begin
                            phase <= FP_HOLD;
                            timer <= TW'(CS_HOLD_CYC);
                        end else begin
                            idx <= idx + 1'b1;
                            go  <= 1'b1;
                        end
                    end
                end
                FP_HOLD: begin
                    if (!timer_zero) begin
                        timer <= timer - 1'b1;
                    end else begin
                        cs_n  <= 1'b1;
                        phase <= FP_OFF;
                        if (st_nx == ST_RSTWAIT) timer <= TW'(RSTWAIT_CYC);
                        if (state == ST_RDATA) begin
                            result       <= {res_hi, res_lo};
                            result_valid <= 1'b1;
                        end
                    end
                end
                default: phase <= FP_OFF;
            endcase
        end
    end

    // ---------------- assertions ----------------
    localparam int CMAX = T_B + 1;
    localparam int CW   = $clog2(CMAX + 1);
    logic [CW-1:0] low_cnt, fall_cnt;
    logic          sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            fall_cnt <= '0;
            sclk_d   <= 1'b0;
        end else begin
            sclk_d <= sclk;
            if (cs_n)                         low_cnt <= '0;
            else if (low_cnt != CW'(CMAX))    low_cnt <= low_cnt + 1'b1;
            if (sclk_d && !sclk)              fall_cnt <= '0;
            else if (fall_cnt != CW'(CMAX))   fall_cnt <= fall_cnt + 1'b1;
        end
    end

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    p_cs_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (low_cnt >= CW'(CS_SETUP_CYC)));

    p_cs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (fall_cnt >= CW'(CS_HOLD_CYC)));

    p_cfg_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    p_valid_at_cs_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $rose(cs_n));

    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> (cs_n && !sclk));

endmodule

// File: tb/adc_seq_host_bench.sv
module adc_seq_host_bench;
    localparam int HALF = 2;
    localparam int PWR  = 200;
    localparam int RSTW = 120;
    localparam int CSS  = 3;
    localparam int CSH  = 2;
    localparam int NR   = 3;
    localparam int BASE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NR*8-1:0] cfg = '0;
    logic drdy_n = 1'b1;
    logic stop_req = 1'b0;
    logic miso = 1'b0;
    logic cs_n, sclk, mosi, result_valid, cfg_err;
    logic [15:0] result;

    adc_seq_host #(
        .SCLK_HALF(HALF), .PWRUP_CYC(PWR), .RSTWAIT_CYC(RSTW),
        .CS_SETUP_CYC(CSS), .CS_HOLD_CYC(CSH), .NREG(NR), .CFG_BASE(BASE),
        .DO_RESET(1'b1), .DO_STATUS(1'b1)
    ) u_adc_seq_host (
        .clk(clk), .rst_n(rst_n), .cfg_regs(cfg), .drdy_n(drdy_n),
        .stop_req(stop_req), .miso(miso), .cs_n(cs_n), .sclk(sclk),
        .mosi(mosi), .result(result), .result_valid(result_valid),
        .cfg_err(cfg_err)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [7:0] c);
        case (c)
            8'h06:        return "R4";
            8'h21, 8'h41: return "R5";
            8'h08:        return "R7";
            8'h12:        return "R8";
            8'h0A:        return "R10";
            default:      return "R6";
        endcase
    endfunction

    // converter model state
    logic [7:0] exp_q[$];
    int         exp_len_q[$];
    logic [7:0] fb[$];
    logic [7:0] mirror[NR];
    logic [7:0] cmd, cur;
    logic [15:0] sample = 16'h0000;
    bit  corrupt = 0;
    bit  cs_q, sclk_q, mosi_q, first_rise, last_reset;
    int  cyc, frames, valids, stat_reads, nbytes, bitc;
    int  cs_fall_cyc, last_fall_cyc, last_rise_cyc;

    function automatic logic [7:0] resp(input int k);
        if (k == 0) return 8'h00;
        if (cmd == 8'h21 && k == 2) return (stat_reads == 0) ? 8'h40 : 8'h80;
        if (cmd == 8'(8'h20 + BASE) && k >= 2 && k - 2 < NR)
            return mirror[k-2] ^ ((corrupt && k == 3) ? 8'h10 : 8'h00);
        if (cmd == 8'h12) return (k == 1) ? sample[15:8] : sample[7:0];
        return 8'h00;
    endfunction

    task automatic push_frame(input logic [7:0] b0, input int n,
                              input logic [7:0] b1, input logic [7:0] b2);
        exp_len_q.push_back(n);
        exp_q.push_back(b0);
        for (int i = 1; i < n; i++) exp_q.push_back(i == 1 ? b1 : (i == 2 ? b2 : 8'h00));
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; frames = 0; valids = 0; stat_reads = 0;
            nbytes = 0; bitc = 0; fb.delete(); last_reset = 0;
            for (int i = 0; i < NR; i++) mirror[i] = 8'h00;
            cs_q = 1; sclk_q = 0; mosi_q = mosi; miso = 0; cmd = 0; cur = 0;
        end else begin
            cyc++;
            chk(!(cs_n && sclk), "R2", "sclk high with cs_n high", sclk, 0);
            if (!(sclk && !sclk_q))
                chk(mosi == mosi_q, "R2", "mosi moved off a rising edge", mosi, mosi_q);
            if (result_valid) begin
                valids++;
                chk(result == sample, "R8", "result word", result, sample);
                chk(cs_n && !cs_q, "R8", "strobe not at cs_n rise", cs_n, 1);
            end
            if (!cs_n && cs_q) begin
                if (frames == 0) chk(cyc >= PWR, "R1", "first frame too early", cyc, PWR);
                if (last_reset)
                    chk(cyc - last_rise_cyc >= RSTW, "R4", "reset recovery gap",
                        cyc - last_rise_cyc, RSTW);
                cs_fall_cyc = cyc; nbytes = 0; bitc = 0; fb.delete();
                first_rise = 1; cmd = 0;
            end
            if (!cs_n && sclk && !sclk_q) begin
                if (first_rise)
                    chk(cyc - cs_fall_cyc >= CSS, "R3", "cs setup", cyc - cs_fall_cyc, CSS);
                first_rise = 0;
                miso = resp(nbytes) >> (7 - bitc);
            end
            if (!cs_n && !sclk && sclk_q) begin
                cur = {cur[6:0], mosi};
                bitc++;
                last_fall_cyc = cyc;
                if (bitc == 8) begin
                    fb.push_back(cur);
                    if (nbytes == 0) cmd = cur;
                    if (cmd == 8'(8'h40 + BASE) && nbytes >= 2 && nbytes - 2 < NR)
                        mirror[nbytes-2] = cur;
                    nbytes++;
                    bitc = 0;
                end
            end
            if (cs_n && !cs_q) begin
                chk(cyc - last_fall_cyc >= CSH, "R3", "cs hold", cyc - last_fall_cyc, CSH);
                if (exp_len_q.size() == 0) begin
                    chk(0, "R10", "unexpected frame", fb.size() > 0 ? fb[0] : 0, 0);
                end else begin
                    int n;
                    bit ok;
                    logic [7:0] e0;
                    n = exp_len_q.pop_front();
                    ok = (fb.size() == n);
                    e0 = exp_q[0];
                    for (int i = 0; i < n; i++) begin
                        logic [7:0] b;
                        b = exp_q.pop_front();
                        if (i < fb.size() && fb[i] != b) ok = 0;
                    end
                    chk(ok, tag_of(e0), "frame bytes", fb.size() > 0 ? fb[0] : 0, e0);
                end
                if (cmd == 8'h21) stat_reads++;
                last_reset = (cmd == 8'h06);
                last_rise_cyc = cyc;
                frames++;
            end
            cs_q = cs_n; sclk_q = sclk; mosi_q = mosi;
        end
    end

    task automatic pulse_drdy();
        drdy_n = 1'b0;
        repeat (5) @(negedge clk);
        drdy_n = 1'b1;
    endtask

    task automatic wait_frames(input int n);
        while (frames < n) @(negedge clk);
    endtask

    task automatic wait_valids(input int n);
        while (valids < n) @(negedge clk);
    endtask

    task automatic run(input bit corr);
        int f0, v0;
        rst_n = 1'b0; corrupt = corr; drdy_n = 1'b1; stop_req = 1'b0;
        cfg = {8'hC7, 8'h13, 8'h5A};
        exp_q.delete(); exp_len_q.delete();
        push_frame(8'h06, 1, 8'h00, 8'h00);
        push_frame(8'h21, 3, 8'h00, 8'h00);
        push_frame(8'h21, 3, 8'h00, 8'h00);
        push_frame(8'h41, 3, 8'h00, 8'h00);
        exp_len_q.push_back(5);
        exp_q.push_back(8'(8'h40 + BASE)); exp_q.push_back(8'h02);
        exp_q.push_back(8'h5A); exp_q.push_back(8'h13); exp_q.push_back(8'hC7);
        push_frame(8'(8'h20 + BASE), 5, 8'h02, 8'h00);
        push_frame(8'h08, 1, 8'h00, 8'h00);
        repeat (5) @(negedge clk);
        chk(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
        chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
        chk(result_valid == 1'b0 && cfg_err == 1'b0, "R1", "flags in reset",
            {result_valid, cfg_err}, 0);
        rst_n = 1'b1;
        wait_frames(7);
        repeat (10) @(negedge clk);
        chk(cfg_err == corr, "R6", "readback mismatch flag", cfg_err, corr);
        chk(stat_reads == 2, "R5", "status polls", stat_reads, 2);

        // R8: single read
        sample = 16'hA5C3;
        push_frame(8'h12, 3, 8'h00, 8'h00);
        v0 = valids;
        pulse_drdy();
        wait_valids(v0 + 1);

        if (!corr) begin
            // R9: edge during an active read frame is kept
            sample = 16'h3C5A;
            push_frame(8'h12, 3, 8'h00, 8'h00);
            push_frame(8'h12, 3, 8'h00, 8'h00);
            v0 = valids;
            pulse_drdy();
            while (cs_n) @(negedge clk);
            repeat (4) @(negedge clk);
            pulse_drdy();
            repeat (300) @(negedge clk);
            chk(valids == v0 + 2, "R9", "reads after overlapping edge", valids - v0, 2);

            // R11: long low level yields one read
            sample = 16'h8001;
            push_frame(8'h12, 3, 8'h00, 8'h00);
            v0 = valids;
            drdy_n = 1'b0;
            repeat (400) @(negedge clk);
            drdy_n = 1'b1;
            repeat (100) @(negedge clk);
            chk(valids == v0 + 1, "R11", "reads for one held level", valids - v0, 1);
        end

        // R10: stop during a read
        sample = 16'h7FFE;
        push_frame(8'h12, 3, 8'h00, 8'h00);
        push_frame(8'h0A, 1, 8'h00, 8'h00);
        f0 = frames; v0 = valids;
        pulse_drdy();
        while (cs_n) @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        wait_frames(f0 + 2);
        chk(valids == v0 + 1, "R10", "read drained before stop", valids - v0, 1);
        repeat (20) @(negedge clk);
        pulse_drdy();
        repeat (300) @(negedge clk);
        chk(frames == f0 + 2 && cs_n == 1'b1, "R10", "frames after stop", frames - f0, 2);
    endtask

    initial begin
        run(1'b0);
        run(1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule